// File: doc/BRIEF.md
# Byte-Bus DAC Write Sequencer

This controller sits on the host side of a 12-bit digital-to-analog converter. The converter has a double-buffered register and is reached over an 8-bit data path. The controller accepts one sample at a time on a valid/ready handshake. It splits the sample into two bytes and writes them in two strobed bus cycles. The first cycle goes to location 01 and the second to location 10. The second write completes the word and moves it to the converter output in one step.

A mode input selects how the 12 bits are packed into the two bytes. Left-justified packing suits software that holds the sample as a binary fraction. Right-justified packing suits software that holds it as an integer. Setup time and strobe width are parameters counted in clock cycles, so the same block can meet the converter's nanosecond limits at any clock rate. A one-cycle done pulse tells the host that the output has been updated.

Top module: `dac_byte_writer`

## Requirements
- R1: While reset is held and after it is released, chip select is high, done is low, in_ready is high, and the address and data outputs are zero.
- R2: in_ready is high only while the sequencer is idle. A sample is taken when in_valid and in_ready are both high at a clock edge, and the word and the mode are captured on that edge. With in_valid low, the bus stays quiet (chip select high, address zero).
- R3: Every accepted word produces exactly two chip-select pulses: the first with address 2'b01, the second with address 2'b10.
- R4: With just_left_i = 1, the first byte is {word[3:0], 4'b0000} and the second byte is word[11:4].
- R5: With just_left_i = 0, the first byte is word[7:0] and the second byte is {4'b0000, word[11:8]}.
- R6: For each write, address and data are driven for ADDR_SETUP cycles with chip select high before chip select falls. They stay unchanged for the whole low pulse.
- R7: Each chip-select low pulse lasts exactly max(CS_WIDTH, DATA_SETUP) cycles.
- R8: Between the two pulses, chip select is high for one cycle, with the first address and byte still driven.
- R9: done is high for exactly one cycle, the cycle right after chip select rises at the end of the second write. in_ready returns high on the next cycle.
- R10: Changes on in_valid, in_word_i and just_left_i while a transfer is in progress have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Ready to take a sample (high only when idle) |
| in_word_i | input | 12 | Sample to convert |
| just_left_i | input | 1 | 1 = left-justified packing, 0 = right-justified packing |
| dac_cs_no | output | 1 | Converter chip select, active low |
| dac_addr_o | output | 2 | Converter latch location |
| dac_data_o | output | 8 | Converter data byte |
| done_o | output | 1 | One-cycle pulse when the output has been updated |

## Verification
The assertions assume ADDR_SETUP is at least one. This lets address and data settle before chip select falls. They also assume reset is applied before any transfer starts. The bench drives all inputs on the falling clock edge, so every input is stable at the sampling edge. During one run it holds in_valid high with a different word and the opposite mode for the whole transfer. This checks that the captured sample governs both writes.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP1,
    ST_STROBE1,
    ST_GAP,
    ST_SETUP2,
    ST_STROBE2,
    ST_DONE
  } wr_state_e;

  localparam logic [1:0] LOC_IDLE   = 2'b00;
  localparam logic [1:0] LOC_FIRST  = 2'b01;
  localparam logic [1:0] LOC_SECOND = 2'b10;

endpackage

// File: rtl/dac_byte_packer.sv
module dac_byte_packer #(
  parameter int WORD_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              left_i,
  output logic [BYTE_W-1:0] first_o,
  output logic [BYTE_W-1:0] second_o
);

  localparam int LO_W  = WORD_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  logic [BYTE_W-1:0] left_first, left_second, right_first, right_second;

  assign left_second = word_i[WORD_W-1:LO_W];
  assign right_first = word_i[BYTE_W-1:0];

  generate
    if (PAD_W == 0) begin : g_no_pad
      assign left_first   = word_i[LO_W-1:0];
      assign right_second = word_i[WORD_W-1:BYTE_W];
    end else begin : g_pad
      assign left_first   = {word_i[LO_W-1:0], {PAD_W{1'b0}}};
      assign right_second = {{PAD_W{1'b0}}, word_i[WORD_W-1:BYTE_W]};
    end
  endgenerate

  assign first_o  = left_i ? left_first  : right_first;
  assign second_o = left_i ? left_second : right_second;

endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == len_i - 1'b1);

  // phase count never runs past the selected length (R7)
  p_cnt_in_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_i);

endmodule

// File: rtl/dac_byte_writer.sv
module dac_byte_writer
  import dac_wr_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int BYTE_W     = 8,
  parameter int ADDR_SETUP = 20,
  parameter int CS_WIDTH   = 20,
  parameter int DATA_SETUP = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              just_left_i,
  output logic              dac_cs_no,
  output logic [1:0]        dac_addr_o,
  output logic [BYTE_W-1:0] dac_data_o,
  output logic              done_o
);

  localparam int STROBE_LEN = (CS_WIDTH > DATA_SETUP) ? CS_WIDTH : DATA_SETUP;
  localparam int MAX_LEN    = (STROBE_LEN > ADDR_SETUP) ? STROBE_LEN : ADDR_SETUP;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] SETUP_LEN  = CNT_W'(ADDR_SETUP);
  localparam logic [CNT_W-1:0] STROBE_CNT = CNT_W'(STROBE_LEN);
  localparam logic [CNT_W-1:0] ONE_LEN    = CNT_W'(1);

  wr_state_e         state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic              left_q;
  logic [CNT_W-1:0]  len;
  logic              last, clear;
  logic [BYTE_W-1:0] byte_first, byte_second;

  dac_byte_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_packer (
    .word_i  (word_q),
    .left_i  (left_q),
    .first_o (byte_first),
    .second_o(byte_second)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .len_i  (len),
    .last_o (last)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP1, ST_SETUP2:   len = SETUP_LEN;
      ST_STROBE1, ST_STROBE2: len = STROBE_CNT;
      default:                len = ONE_LEN;
    endcase
  end

  assign clear = (state_q == ST_IDLE) || last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (in_valid_i) state_d = ST_SETUP1;
      ST_SETUP1:  if (last) state_d = ST_STROBE1;
      ST_STROBE1: if (last) state_d = ST_GAP;
      ST_GAP:     state_d = ST_SETUP2;
      ST_SETUP2:  if (last) state_d = ST_STROBE2;
      ST_STROBE2: if (last) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      left_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && in_valid_i) begin
        word_q <= in_word_i;
        left_q <= just_left_i;
      end
    end
  end

  logic first_phase, second_phase;
  assign first_phase  = state_q inside {ST_SETUP1, ST_STROBE1, ST_GAP};
  assign second_phase = state_q inside {ST_SETUP2, ST_STROBE2, ST_DONE};

  assign in_ready_o = (state_q == ST_IDLE);
  assign dac_cs_no  = !(state_q inside {ST_STROBE1, ST_STROBE2});
  assign done_o     = (state_q == ST_DONE);
  assign dac_addr_o = first_phase ? LOC_FIRST : (second_phase ? LOC_SECOND : LOC_IDLE);
  assign dac_data_o = first_phase ? byte_first : (second_phase ? byte_second : '0);

  // low-pulse length tracker for the width check
  logic [CNT_W-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_run_q <= '0;
    else if (dac_cs_no) low_run_q <= '0;
    else                low_run_q <= low_run_q + 1'b1;
  end

  p_ready_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> dac_cs_no && !done_o);

  p_hold_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no && $past(!dac_cs_no)) |-> $stable(dac_addr_o) && $stable(dac_data_o));

  p_setup_before_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_cs_no) |-> $stable(dac_addr_o) && $stable(dac_data_o) && dac_addr_o != LOC_IDLE);

  p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_cs_no) |-> low_run_q == STROBE_CNT);

  p_hold_after_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_cs_no) |-> $stable(dac_addr_o) && $stable(dac_data_o));

  p_done_after_second_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!dac_cs_no) && dac_addr_o == LOC_SECOND);

  p_ready_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> in_ready_o && !done_o);

  p_first_loc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && in_valid_i) |=> dac_addr_o == LOC_FIRST);

endmodule

// File: tb/test_dac_byte_writer.sv
`timescale 1ns/1ps
module test_dac_byte_writer;

  localparam int A  = 2;
  localparam int CW = 3;
  localparam int DS = 4;
  localparam int S  = (CW > DS) ? CW : DS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_word = '0;
  logic        just_left = 1'b0;
  logic        cs_n;
  logic [1:0]  addr;
  logic [7:0]  data;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dac_byte_writer #(
    .WORD_W(12), .BYTE_W(8), .ADDR_SETUP(A), .CS_WIDTH(CW), .DATA_SETUP(DS)
  ) i_dac_byte_writer (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_word_i(in_word), .just_left_i(just_left), .dac_cs_no(cs_n),
    .dac_addr_o(addr), .dac_data_o(data), .done_o(done)
  );

  // bus snapshot: {cs_n, addr, data, done, ready}
  function automatic logic [12:0] snap();
    return {cs_n, addr, data, done, in_ready};
  endfunction

  task automatic chk(input logic [12:0] exp, input string tag);
    logic [12:0] act;
    act = snap();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk({1'b1, 2'b00, 8'h00, 1'b0, 1'b1}, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({1'b1, 2'b00, 8'h00, 1'b0, 1'b1}, "R1 after reset");
  endtask

  task automatic test_idle_quiet();
    in_valid = 1'b0;
    in_word  = 12'h3A5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({1'b1, 2'b00, 8'h00, 1'b0, 1'b1}, "R2 idle without valid");
    end
  endtask

  // one full transfer; junk keeps valid high with other inputs while busy (R10)
  task automatic run_xfer(input logic [11:0] w, input logic left, input logic junk);
    logic [7:0] b1, b2;
    string      ptag;
    int         total;
    if (left) begin
      b1 = {w[3:0], 4'h0}; b2 = w[11:4]; ptag = junk ? "R10 R4" : "R4";
    end else begin
      b1 = w[7:0]; b2 = {4'h0, w[11:8]}; ptag = junk ? "R10 R5" : "R5";
    end
    total = 2*A + 2*S + 2;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; just_left = left;
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R2 ready before accept: actual %b expected 1", in_ready);
    end
    @(negedge clk);
    if (junk) begin
      in_word = ~w; just_left = ~left;
    end else begin
      in_valid = 1'b0;
    end
    for (int i = 0; i <= total; i++) begin
      if (i < A)
        chk({1'b1, 2'b01, b1, 1'b0, 1'b0}, {ptag, " R6 setup1"});
      else if (i < A + S)
        chk({1'b0, 2'b01, b1, 1'b0, 1'b0}, {ptag, " R7 strobe1"});
      else if (i == A + S)
        chk({1'b1, 2'b01, b1, 1'b0, 1'b0}, {ptag, " R8 gap"});
      else if (i < 2*A + S + 1)
        chk({1'b1, 2'b10, b2, 1'b0, 1'b0}, {ptag, " R3 setup2"});
      else if (i < 2*A + 2*S + 1)
        chk({1'b0, 2'b10, b2, 1'b0, 1'b0}, {ptag, " R7 strobe2"});
      else if (i == 2*A + 2*S + 1) begin
        chk({1'b1, 2'b10, b2, 1'b1, 1'b0}, {ptag, " R9 done"});
        in_valid = 1'b0;
      end else
        chk({1'b1, 2'b00, 8'h00, 1'b0, 1'b1}, {ptag, " R9 ready again"});
      if (i < total) @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_idle_quiet();
    run_xfer(12'hABC, 1'b1, 1'b0);
    run_xfer(12'hABC, 1'b0, 1'b0);
    run_xfer(12'hFFF, 1'b1, 1'b0);
    run_xfer(12'h000, 1'b0, 1'b0);
    run_xfer(12'h800, 1'b0, 1'b0);
    run_xfer(12'h7FF, 1'b1, 1'b0);
    run_xfer(12'h5A3, 1'b1, 1'b1);
    run_xfer(12'h1E7, 1'b0, 1'b1);
    test_idle_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule